// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM Core with Lane Writes

This block is a synchronous static memory whose address and access controls are captured on the rising clock edge, while read data leaves the array without an output register. A word that is read is therefore visible in the same cycle that follows the edge capturing its address. The word is split into equal byte lanes. A global write stores every lane at once. A lane write stores only the lanes whose individual enables are asserted.

The address comes from an external burst sequencer. On cycles that load a new address, the chip enables and write controls are decoded and stored. On burst continuation cycles, the stored access type and lane mask are applied to the address the sequencer supplies.

Three chip enables of mixed polarity qualify each access. An asynchronous active-low output enable gates the read bus. A sleep input suspends all activity and keeps the stored contents. The shared data pins are modelled as separate input and output buses, plus a flag that marks when the output would be driven.

Top module: `ftsram_core`

## Requirements
- R1: When `gw_n` is low on a selected, loaded cycle, every lane of the word at `addr_in` is written from `din`, whatever the values of `bw_n` and `lane_en_n`.
- R2: When `gw_n` is high, `bw_n` is low and at least one bit of `lane_en_n` is low on a selected, loaded cycle, only lane i for which `lane_en_n[i]` is low is written. Lane i occupies bits [i*LANE_W +: LANE_W] of the word.
- R3: A selected, loaded cycle in which neither R1 nor R2 applies is a read and leaves the array unchanged. This covers `bw_n` low with all lane enables high, and `bw_n` high with lane enables low.
- R4: The chip is selected only when `ce_a_n` is 0, `ce_b` is 1 and `ce_c_n` is 0. Any other combination on a loaded cycle writes nothing and leaves `dout_en` low.
- R5: `oe_n` acts without a clock. While it is high, `dout_en` is low. When it falls during a read cycle, `dout_en` rises and the word appears with no clock edge in between.
- R6: The edge that captures a read address presents that word on `dout` with `dout_en` high during the cycle that follows the edge, with no extra cycle of latency.
- R7: While `sleep` is high, no write reaches the array and `dout_en` is low. Any stored access is cancelled to idle. Contents survive sleep, and accesses loaded on the first edge after `sleep` falls behave normally.
- R8: Enables and write controls are sampled only on edges where `addr_load` is 1. On edges where `addr_load` is 0, the stored access type and lane mask are reused at the newly registered address.
- R9: `dout` is all zeros whenever `dout_en` is low. `dout_en` is low after reset and in the cycle after a write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the access registers |
| addr_in | input | ADDR_W | Word address from the burst sequencer |
| addr_load | input | 1 | 1 = new access: sample enables and write controls |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Lane-write qualifier, active low |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power hold, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Output-drive flag |

## Verification
The clocked properties assume that every input is stable around the rising edge and that `addr_load` is a known value on each edge. `sleep` is also assumed not to toggle in the middle of a write on the shared bus. The bench changes all inputs one nanosecond after each edge and samples results there, so every decode happens on settled values. The one exception is `oe_n`, which is moved mid-cycle on purpose to show its unclocked path. Burst continuation is only ever issued after a loaded access or after sleep, which matches the stored-type rule that the hold property relies on.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   localparam int unsigned MAX_ADDR_W = 12;
endpackage

// File: rtl/ftsram_ctrl.sv
module ftsram_ctrl
   import ftsram_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_load,
   input  logic             sleep,
   input  logic             ce_a_n,
   input  logic             ce_b,
   input  logic             ce_c_n,
   input  logic             gw_n,
   input  logic             bw_n,
   input  logic [LANES-1:0] lane_en_n,
   output acc_kind_e        eff_kind,
   output logic [LANES-1:0] eff_mask,
   output acc_kind_e        held_kind
);
   logic             chip_sel;
   acc_kind_e        new_kind;
   logic [LANES-1:0] new_mask;
   logic [LANES-1:0] held_mask;

   assign chip_sel = !ce_a_n && ce_b && !ce_c_n;

   always_comb begin
      new_kind = ACC_IDLE;
      new_mask = '0;
      if (chip_sel) begin
         if (!gw_n) begin
            new_kind = ACC_WRITE;
            new_mask = '1;
         end else if (!bw_n && (|(~lane_en_n))) begin
            new_kind = ACC_WRITE;
            new_mask = ~lane_en_n;
         end else begin
            new_kind = ACC_READ;
         end
      end
   end

   assign eff_kind = addr_load ? new_kind : held_kind;
   assign eff_mask = addr_load ? new_mask : held_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_kind <= ACC_IDLE;
         held_mask <= '0;
      end else if (sleep) begin
         held_kind <= ACC_IDLE;
         held_mask <= '0;
      end else begin
         held_kind <= eff_kind;
         held_mask <= eff_mask;
      end
   end

   AST_BURST_HOLDS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_load && !sleep) |=> ($stable(held_kind) && $stable(held_mask))) // R8
      else $error("stored access changed on a continuation edge");

   AST_SLEEP_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (held_kind == ACC_IDLE)) // R7
      else $error("access survived a sleep edge");

   AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (held_kind == ACC_WRITE) |-> (|held_mask)) // R2
      else $error("stored write with empty lane mask");
endmodule

// File: rtl/ftsram_wdec.sv
module ftsram_wdec
   import ftsram_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input  acc_kind_e        eff_kind,
   input  logic [LANES-1:0] eff_mask,
   input  logic             sleep,
   output logic [LANES-1:0] lane_we
);
   logic wr_ok;

   assign wr_ok = (eff_kind == ACC_WRITE) && !sleep;

   for (genvar li = 0; li < LANES; li++) begin : g_lane
      assign lane_we[li] = wr_ok && eff_mask[li];
   end
endmodule

// File: rtl/ftsram_array.sv
module ftsram_array #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9
) (
   input  logic                      clk,
   input  logic [LANES-1:0]          lane_we,
   input  logic [ADDR_W-1:0]         waddr,
   input  logic [LANES*LANE_W-1:0]   wdata,
   input  logic [ADDR_W-1:0]         raddr,
   output logic [LANES*LANE_W-1:0]   rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   for (genvar li = 0; li < LANES; li++) begin : g_lane
      logic [LANE_W-1:0] lane_mem [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[li]) lane_mem[waddr] <= wdata[li*LANE_W +: LANE_W];
      end

      assign rdata[li*LANE_W +: LANE_W] = lane_mem[raddr];
   end
endmodule

// File: rtl/ftsram_core.sv
module ftsram_core
   import ftsram_pkg::*;
#(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned LANES     = 4,
   parameter int unsigned LANE_W    = 9,
   parameter bit          IDLE_ZERO = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr_in,
   input  logic                    addr_load,
   input  logic                    ce_a_n,
   input  logic                    ce_b,
   input  logic                    ce_c_n,
   input  logic                    gw_n,
   input  logic                    bw_n,
   input  logic [LANES-1:0]        lane_en_n,
   input  logic                    oe_n,
   input  logic                    sleep,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_en
);
   localparam int unsigned WORD_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_addr_w
      $error("ADDR_W out of range");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("LANE_W must be at least 1");
   end

   acc_kind_e          eff_kind;
   acc_kind_e          held_kind;
   logic [LANES-1:0]   eff_mask;
   logic [LANES-1:0]   lane_we;
   logic [ADDR_W-1:0]  addr_q;
   logic [WORD_W-1:0]  rdata;

   ftsram_ctrl #(.LANES(LANES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_load (addr_load),
      .sleep     (sleep),
      .ce_a_n    (ce_a_n),
      .ce_b      (ce_b),
      .ce_c_n    (ce_c_n),
      .gw_n      (gw_n),
      .bw_n      (bw_n),
      .lane_en_n (lane_en_n),
      .eff_kind  (eff_kind),
      .eff_mask  (eff_mask),
      .held_kind (held_kind)
   );

   ftsram_wdec #(.LANES(LANES)) u_wdec (
      .eff_kind (eff_kind),
      .eff_mask (eff_mask),
      .sleep    (sleep),
      .lane_we  (lane_we)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr_in;
   end

   ftsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk     (clk),
      .lane_we (lane_we),
      .waddr   (addr_in),
      .wdata   (din),
      .raddr   (addr_q),
      .rdata   (rdata)
   );

   assign dout_en = (held_kind == ACC_READ) && !oe_n && !sleep;

   if (IDLE_ZERO) begin : g_zero_out
      assign dout = dout_en ? rdata : '0;
   end else begin : g_raw_out
      assign dout = rdata;
   end

   AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (lane_we == '0)) // R7
      else $error("write enable raised during sleep");

   AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_load && !gw_n && !ce_a_n && ce_b && !ce_c_n && !sleep) |-> (&lane_we)) // R1
      else $error("global write missed a lane");

   AST_DESELECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_load && !(!ce_a_n && ce_b && !ce_c_n)) |-> (lane_we == '0)) // R4
      else $error("write while deselected");

   AST_QUIET_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (held_kind == ACC_WRITE) |-> !dout_en) // R9
      else $error("output driven in a write cycle");
endmodule

// File: tb/ftsram_core_bench.sv
`timescale 1ns/1ps
module ftsram_core_bench;
   localparam int unsigned AW = 6;
   localparam int unsigned NB = 4;
   localparam int unsigned LW = 9;
   localparam int unsigned W  = NB * LW;
   localparam logic [2:0] SEL = 3'b010; // {ce_a_n, ce_b, ce_c_n}

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr_in;
   logic          addr_load;
   logic          ce_a_n, ce_b, ce_c_n;
   logic          gw_n, bw_n;
   logic [NB-1:0] lane_en_n;
   logic          oe_n;
   logic          sleep;
   logic [W-1:0]  din;
   logic [W-1:0]  dout;
   logic          dout_en;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   ftsram_core u_ftsram_core (
      .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .addr_load(addr_load),
      .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .gw_n(gw_n), .bw_n(bw_n),
      .lane_en_n(lane_en_n), .oe_n(oe_n), .sleep(sleep), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic set_bus(input logic [AW-1:0] a, input logic ld, input logic [2:0] ce,
                          input logic g, input logic b, input logic [NB-1:0] ln,
                          input logic [W-1:0] d);
      addr_in = a; addr_load = ld;
      {ce_a_n, ce_b, ce_c_n} = ce;
      gw_n = g; bw_n = b; lane_en_n = ln; din = d;
   endtask

   task automatic gwrite(input logic [AW-1:0] a, input logic [W-1:0] d);
      set_bus(a, 1'b1, SEL, 1'b0, 1'b1, '1, d);
      tick;
   endtask

   task automatic read_expect(input string tag, input logic [AW-1:0] a, input logic [W-1:0] exp);
      set_bus(a, 1'b1, SEL, 1'b1, 1'b1, '1, '0);
      tick;
      chk({tag, " en"}, W'(dout_en), W'(1));
      chk({tag, " data"}, dout, exp);
   endtask

   task automatic t_reset;
      chk("R9 reset en", W'(dout_en), '0);
      chk("R9 reset data", dout, '0);
   endtask

   task automatic t_global;
      gwrite(6'd3, 36'h123456789);
      chk("R9 write cycle en", W'(dout_en), '0);
      chk("R9 write cycle data", dout, '0);
      read_expect("R1 gw", 6'd3, 36'h123456789);
      set_bus(6'd3, 1'b1, SEL, 1'b0, 1'b0, 4'b1110, 36'hABCDEF012);
      tick;
      read_expect("R1 gw overrides lanes", 6'd3, 36'hABCDEF012);
   endtask

   task automatic t_lanes;
      gwrite(6'd5, '0);
      set_bus(6'd5, 1'b1, SEL, 1'b1, 1'b0, 4'b1010, '1);
      tick;
      read_expect("R2 lanes 0 and 2", 6'd5, 36'h007FC01FF);
      set_bus(6'd5, 1'b1, SEL, 1'b1, 1'b0, 4'b1111, '1);
      tick;
      chk("R3 bw no lanes reads en", W'(dout_en), W'(1));
      chk("R3 bw no lanes reads data", dout, 36'h007FC01FF);
      set_bus(6'd5, 1'b1, SEL, 1'b1, 1'b1, 4'b0000, '1);
      tick;
      read_expect("R3 lanes without bw", 6'd5, 36'h007FC01FF);
   endtask

   task automatic t_select;
      gwrite(6'd7, 36'h555555555);
      foreach (bad_ce[i]) begin
         set_bus(6'd7, 1'b1, bad_ce[i], 1'b0, 1'b1, '1, '0);
         tick;
         chk("R4 deselected en", W'(dout_en), '0);
         set_bus(6'd7, 1'b1, bad_ce[i], 1'b1, 1'b1, '1, '0);
         tick;
         chk("R4 deselected read en", W'(dout_en), '0);
         chk("R9 deselected data", dout, '0);
      end
      read_expect("R4 word kept", 6'd7, 36'h555555555);
   endtask

   logic [2:0] bad_ce [3] = '{3'b110, 3'b000, 3'b011};

   task automatic t_oe;
      oe_n = 1'b1;
      set_bus(6'd3, 1'b1, SEL, 1'b1, 1'b1, '1, '0);
      tick;
      chk("R5 oe high en", W'(dout_en), '0);
      chk("R9 oe high data", dout, '0);
      #1 oe_n = 1'b0;
      #0.5;
      chk("R5 oe async en", W'(dout_en), W'(1));
      chk("R5 oe async data", dout, 36'hABCDEF012);
   endtask

   task automatic t_flow;
      gwrite(6'd10, 36'h0F0F0F0F0);
      gwrite(6'd11, 36'h123123123);
      read_expect("R6 flow a", 6'd10, 36'h0F0F0F0F0);
      read_expect("R6 flow b", 6'd11, 36'h123123123);
      read_expect("R6 flow c", 6'd10, 36'h0F0F0F0F0);
   endtask

   task automatic t_sleep;
      sleep = 1'b1;
      set_bus(6'd3, 1'b1, SEL, 1'b0, 1'b1, '1, '0);
      tick;
      chk("R7 sleep write en", W'(dout_en), '0);
      set_bus(6'd3, 1'b1, SEL, 1'b1, 1'b1, '1, '0);
      tick;
      chk("R7 sleep read en", W'(dout_en), '0);
      sleep = 1'b0;
      #0.5;
      chk("R7 sleep cancelled access en", W'(dout_en), '0);
      set_bus(6'd4, 1'b0, SEL, 1'b1, 1'b1, '1, '0);
      tick;
      chk("R7 continuation idle after sleep", W'(dout_en), '0);
      read_expect("R7 retained", 6'd3, 36'hABCDEF012);
   endtask

   task automatic t_burst;
      gwrite(6'd20, 36'h111111111);
      set_bus(6'd21, 1'b0, 3'b110, 1'b1, 1'b1, '1, 36'h222222222);
      tick;
      read_expect("R8 burst read first", 6'd20, 36'h111111111);
      set_bus(6'd21, 1'b0, SEL, 1'b0, 1'b1, '1, 36'h999999999);
      tick;
      chk("R8 burst read cont en", W'(dout_en), W'(1));
      chk("R8 burst write cont data", dout, 36'h222222222);
      read_expect("R8 no write on read cont", 6'd21, 36'h222222222);
      gwrite(6'd22, '0);
      gwrite(6'd23, '0);
      set_bus(6'd22, 1'b1, SEL, 1'b1, 1'b0, 4'b1110, '1);
      tick;
      set_bus(6'd23, 1'b0, SEL, 1'b1, 1'b0, 4'b0000, '1);
      tick;
      read_expect("R8 mask lane0 first", 6'd22, 36'h0000001FF);
      read_expect("R8 mask reused", 6'd23, 36'h0000001FF);
   endtask

   initial begin
      #(5.0 * 100000);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
      set_bus('0, 1'b1, 3'b110, 1'b1, 1'b1, '1, '0);
      repeat (3) tick;
      rst_n = 1'b1;
      tick;
      t_reset;
      t_global;
      t_lanes;
      t_select;
      t_oe;
      t_flow;
      t_sleep;
      t_burst;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule